// File: doc/BRIEF.md
# Transport-Layer Lane Packer for a Multi-Lane Serial Link

This block takes groups of complex decimated samples and spreads them over up to five lane octet streams, one octet per lane per character clock. Each sample is 15 data bits with a control bit appended, which gives a 16-bit word. That word always occupies two characters on its lane, and the upper octet goes first. A 3-bit layout code picks one of seven arrangements. The arrangements differ in how many lanes they use, how many characters make up a frame, and whether an I/Q group is split across lanes, spread one sample per lane, or filled out with zero tail words.

The layout code is captured only while the synchronous reset is asserted. After reset, the block accepts a whole sample group through a ready/valid handshake. It then plays that group out as one frame and marks the first character of the frame on every active lane. A new group is taken only in the last character of a frame, or when no frame is in flight, so frames follow each other without gaps and a frame is never torn. Lanes that the layout does not use stay at zero.

Top module: `lane_packer`

## Requirements
- R1: While reset is held and in the cycle after it is released, all lane octets and frame markers are zero and `frame_active` is low. `grp_ready` is high for every layout code except 7.
- R2: A sample word is {data[14:0], ctl}. The character at frame position 2p carries word bits 15:8 and position 2p+1 carries bits 7:0, where p is the word's position on its lane.
- R3: Code 0 uses 5 lanes and 4-character frames, with five I and five Q samples per group. Lanes 0 to 4 carry (I0,I1), (I2,I3), (I4,Q0), (Q1,Q2) and (Q3,Q4).
- R4: Code 1 uses 4 lanes and 2-character frames, with two I and two Q samples per group. Lane 0 carries I0, lane 1 I1, lane 2 Q0 and lane 3 Q1.
- R5: Code 2 uses 3 lanes and 8-character frames. Lane 0 carries I0..I3, lane 1 carries I4,Q0,Q1,Q2, and lane 2 carries Q3,Q4 followed by two all-zero tail words.
- R6: Code 3 uses 2 lanes and 2-character frames. Lane 0 carries I0 and lane 1 carries Q0.
- R7: Code 4 uses 2 lanes and 16-character frames. Lane 0 carries I0..I4 then Q0..Q2. Lane 1 carries Q3,Q4 followed by six zero tail words.
- R8: Code 5 uses 1 lane and 4-character frames, sending I0 and then Q0.
- R9: Code 6 uses 1 lane and 32-character frames, sending I0..I4, then Q0..Q4, then six zero tail words.
- R10: `lane_en` has its lowest L bits set for a layout with L lanes. Every lane at or above L outputs zero octets and never raises its frame marker.
- R11: `lane_sof` is high on every active lane, and only there, in the character that holds octet 0 of a frame.
- R12: `grp_ready` is high only when no frame is in flight or in the last character of a frame. An accepted group starts its frame in the next cycle, and back-to-back groups give gap-free frames. When no group is pending at the end of a frame, `frame_active` falls and all lanes go to zero.
- R13: A change of `mode_sel` while reset is released has no effect until the next reset.
- R14: Code 7 enables no lanes and holds `grp_ready` low, so `grp_valid` is ignored and all outputs stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset; also samples `mode_sel` |
| mode_sel | input | 3 | Lane/frame layout code, 0 to 7 |
| grp_valid | input | 1 | A sample group is offered |
| grp_ready | output | 1 | The offered group is taken on this edge |
| grp_i_data | input | 75 | Five I data fields, sample k at bits 15k+14:15k |
| grp_i_ctl | input | 5 | Control bit of I sample k at bit k |
| grp_q_data | input | 75 | Five Q data fields, sample k at bits 15k+14:15k |
| grp_q_ctl | input | 5 | Control bit of Q sample k at bit k |
| lane_octet | output | 40 | Octet of lane l at bits 8l+7:8l |
| lane_sof | output | 5 | Frame-start marker per lane |
| lane_en | output | 5 | Lane in use under the captured layout |
| frame_active | output | 1 | A frame is being played out |

## Verification
The hardest situation to reach is a second group offered while a frame is still going out. This case shows whether the block refuses the group mid-frame, keeps the current frame's contents intact, and takes the new group exactly in the last character so the next frame follows with no gap. The stimulus holds `grp_valid` high with a different group for the whole length of an 8-character frame. It then checks the ready line and the lane contents on every character, and the frame marker on the character just after. Mode capture is exercised in a similar way: `mode_sel` is changed right after reset is released, before any group is offered.

// File: rtl/lane_packer_pkg.sv
// Package: shared sizes, layout codes and layout lookup functions for the lane packer.
// Assumes five samples of each of I and Q per group at most, and five lanes.
package lane_packer_pkg;

    localparam int NUM_LANES   = 5;
    localparam int GRP_SAMPLES = 5;
    localparam int DATA_W      = 15;
    localparam int WORD_W      = DATA_W + 1;
    localparam int OCT_W       = 8;
    localparam int NUM_SLOTS   = 2 * GRP_SAMPLES;
    localparam int TAIL_SLOT   = NUM_SLOTS;
    localparam int SLOT_W      = $clog2(NUM_SLOTS + 1);
    localparam int SLOT_TAB    = 2 ** SLOT_W;
    localparam int MAX_FRAME   = 32;
    localparam int CHR_W       = $clog2(MAX_FRAME);
    localparam int LEN_W       = CHR_W + 1;
    localparam int LANE_CNT_W  = $clog2(NUM_LANES + 1);

    typedef enum logic [2:0] {
        LAYOUT_5X4  = 3'd0,
        LAYOUT_4X2  = 3'd1,
        LAYOUT_3X8  = 3'd2,
        LAYOUT_2X2  = 3'd3,
        LAYOUT_2X16 = 3'd4,
        LAYOUT_1X4  = 3'd5,
        LAYOUT_1X32 = 3'd6,
        LAYOUT_OFF  = 3'd7
    } layout_e;

    // Number of lanes a layout drives.
    function automatic logic [LANE_CNT_W-1:0] layout_lanes(layout_e m);
        case (m)
            LAYOUT_5X4:  return LANE_CNT_W'(5);
            LAYOUT_4X2:  return LANE_CNT_W'(4);
            LAYOUT_3X8:  return LANE_CNT_W'(3);
            LAYOUT_2X2:  return LANE_CNT_W'(2);
            LAYOUT_2X16: return LANE_CNT_W'(2);
            LAYOUT_1X4:  return LANE_CNT_W'(1);
            LAYOUT_1X32: return LANE_CNT_W'(1);
            default:     return LANE_CNT_W'(0);
        endcase
    endfunction

    // Frame length in characters (octets per lane per frame).
    function automatic logic [LEN_W-1:0] layout_frame_len(layout_e m);
        case (m)
            LAYOUT_5X4:  return LEN_W'(4);
            LAYOUT_4X2:  return LEN_W'(2);
            LAYOUT_3X8:  return LEN_W'(8);
            LAYOUT_2X2:  return LEN_W'(2);
            LAYOUT_2X16: return LEN_W'(16);
            LAYOUT_1X4:  return LEN_W'(4);
            LAYOUT_1X32: return LEN_W'(32);
            default:     return LEN_W'(2);
        endcase
    endfunction

    // Group slot for a lane and word position; slots 0..4 are I, 5..9 are Q, TAIL_SLOT is zero fill.
    function automatic logic [SLOT_W-1:0] layout_slot(layout_e m, int lane,
                                                      logic [CHR_W-2:0] wpos);
        int lin;
        lin = 0;
        case (m)
            LAYOUT_4X2: begin
                case (lane)
                    0:       return SLOT_W'(0);
                    1:       return SLOT_W'(1);
                    2:       return SLOT_W'(GRP_SAMPLES);
                    3:       return SLOT_W'(GRP_SAMPLES + 1);
                    default: return SLOT_W'(TAIL_SLOT);
                endcase
            end
            LAYOUT_2X2: begin
                case (lane)
                    0:       return SLOT_W'(0);
                    1:       return SLOT_W'(GRP_SAMPLES);
                    default: return SLOT_W'(TAIL_SLOT);
                endcase
            end
            LAYOUT_1X4: begin
                if (lane != 0) return SLOT_W'(TAIL_SLOT);
                return (wpos == '0) ? SLOT_W'(0) : SLOT_W'(GRP_SAMPLES);
            end
            LAYOUT_5X4, LAYOUT_3X8, LAYOUT_2X16, LAYOUT_1X32: begin
                lin = lane * (int'(layout_frame_len(m)) / 2) + int'(wpos);
                return (lin < NUM_SLOTS) ? SLOT_W'(lin) : SLOT_W'(TAIL_SLOT);
            end
            default: return SLOT_W'(TAIL_SLOT);
        endcase
    endfunction

endpackage

// File: rtl/lane_packer_seq.sv
// Module: frame sequencer. Captures the layout code during reset, runs the
// character counter within a frame and decides when a new group may be taken.
// Assumes the group source holds its data stable while grp_valid is high.
module lane_packer_seq
    import lane_packer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_in,
    input  logic             grp_valid,
    output logic             grp_ready,
    output logic             load,
    output layout_e          mode_q,
    output logic [CHR_W-1:0] chr,
    output logic             active
);

    logic [CHR_W-1:0] frame_last;
    logic             at_last;
    logic             is_off;

    // Decode frame end and the acceptance window.
    always_comb begin
        frame_last = CHR_W'(layout_frame_len(mode_q) - LEN_W'(1));
        at_last    = active && (chr == frame_last);
        is_off     = (mode_q == LAYOUT_OFF);
        grp_ready  = !is_off && (!active || at_last);
        load       = grp_valid && grp_ready;
    end

    // Mode capture in reset, then frame start and character advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= layout_e'(mode_in);
            active <= 1'b0;
            chr    <= '0;
        end else if (load) begin
            active <= 1'b1;
            chr    <= '0;
        end else if (active) begin
            if (at_last) begin
                active <= 1'b0;
                chr    <= '0;
            end else begin
                chr <= chr + CHR_W'(1);
            end
        end
    end

    AST_LOAD_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n) load |=> (active && chr == '0)); // R12
    AST_NO_TEAR: assert property (@(posedge clk) disable iff (!rst_n) (active && !grp_ready) |=> (active && chr == $past(chr) + CHR_W'(1))); // R12
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) active |=> $stable(mode_q)); // R13
    AST_OFF_NEVER_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (mode_q == LAYOUT_OFF) |-> !load); // R14

endmodule

// File: rtl/lane_packer_lane.sv
// Module: one output lane. Picks the group word for the current character from
// the layout, selects its upper or lower octet and gates the lane when unused.
// Assumes chr counts characters from zero at the frame start.
module lane_packer_lane
    import lane_packer_pkg::*;
#(
    parameter int LANE_IDX = 0
) (
    input  layout_e                    mode_q,
    input  logic                       active,
    input  logic [CHR_W-1:0]           chr,
    input  logic [NUM_SLOTS*WORD_W-1:0] grp_words,
    output logic [OCT_W-1:0]           octet,
    output logic                       sof,
    output logic                       en
);

    logic [WORD_W-1:0] slot_tab [SLOT_TAB];
    logic [SLOT_W-1:0] slot;
    logic [WORD_W-1:0] word;

    // Slot table: group words, then zero for the tail slot and unused codes.
    for (genvar s = 0; s < SLOT_TAB; s++) begin : g_tab
        if (s < NUM_SLOTS) begin : g_word
            assign slot_tab[s] = grp_words[s*WORD_W +: WORD_W];
        end else begin : g_zero
            assign slot_tab[s] = '0;
        end
    end

    // Word lookup, octet select (upper octet first) and lane gating.
    always_comb begin
        en    = (LANE_IDX < int'(layout_lanes(mode_q)));
        slot  = layout_slot(mode_q, LANE_IDX, chr[CHR_W-1:1]);
        word  = slot_tab[slot];
        octet = '0;
        if (en && active) begin
            octet = chr[0] ? word[OCT_W-1:0] : word[WORD_W-1:OCT_W];
        end
        sof   = en && active && (chr == '0);
    end

endmodule

// File: rtl/lane_packer.sv
// Module: top of the lane packer. Holds the accepted sample group and fans it
// out to one lane slice per output lane.
// Assumes mode_sel is meaningful only while rst_n is low.
module lane_packer
    import lane_packer_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [2:0]                      mode_sel,
    input  logic                            grp_valid,
    output logic                            grp_ready,
    input  logic [GRP_SAMPLES*DATA_W-1:0]   grp_i_data,
    input  logic [GRP_SAMPLES-1:0]          grp_i_ctl,
    input  logic [GRP_SAMPLES*DATA_W-1:0]   grp_q_data,
    input  logic [GRP_SAMPLES-1:0]          grp_q_ctl,
    output logic [NUM_LANES*OCT_W-1:0]      lane_octet,
    output logic [NUM_LANES-1:0]            lane_sof,
    output logic [NUM_LANES-1:0]            lane_en,
    output logic                            frame_active
);

    logic                          load;
    layout_e                       mode_q;
    logic [CHR_W-1:0]              chr;
    logic [NUM_SLOTS*WORD_W-1:0]   grp_words;

    lane_packer_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_in   (mode_sel),
        .grp_valid (grp_valid),
        .grp_ready (grp_ready),
        .load      (load),
        .mode_q    (mode_q),
        .chr       (chr),
        .active    (frame_active)
    );

    // Group register: I words in slots 0..4, Q words in slots 5..9, each {data, ctl}.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_words <= '0;
        end else if (load) begin
            for (int k = 0; k < GRP_SAMPLES; k++) begin
                grp_words[k*WORD_W +: WORD_W] <=
                    {grp_i_data[k*DATA_W +: DATA_W], grp_i_ctl[k]};
                grp_words[(GRP_SAMPLES+k)*WORD_W +: WORD_W] <=
                    {grp_q_data[k*DATA_W +: DATA_W], grp_q_ctl[k]};
            end
        end
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        lane_packer_lane #(.LANE_IDX(l)) u_lane (
            .mode_q    (mode_q),
            .active    (frame_active),
            .chr       (chr),
            .grp_words (grp_words),
            .octet     (lane_octet[l*OCT_W +: OCT_W]),
            .sof       (lane_sof[l]),
            .en        (lane_en[l])
        );
        AST_SOF_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) lane_sof[l] |-> lane_sof[0]); // R11
    end

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) lane_sof[0] |=> !lane_sof[0]); // R11
    AST_EN_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n) ((lane_en & (lane_en + NUM_LANES'(1))) == '0)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !frame_active |-> (lane_octet == '0 && lane_sof == '0)); // R12

endmodule

// File: tb/lane_packer_bench.sv
`timescale 1ns/1ps
module lane_packer_bench;

    localparam real CLK_HALF = 10.0;
    localparam logic [63:0] NONE = {16{4'hE}};

    // Per-layout vector: code, lanes, frame length, requirement, token list per lane.
    // Token nibbles from the MSB: 0..4 = I0..I4, 5..9 = Q0..Q4, F = zero tail word.
    typedef struct packed {
        logic [2:0]       mode;
        logic [2:0]       lanes;
        logic [5:0]       flen;
        logic [3:0]       req;
        logic [4:0][63:0] lay;
    } vec_t;

    localparam vec_t VECS [7] = '{
        // R3
        '{3'd0, 3'd5, 6'd4, 4'd3, {64'h89EE_EEEE_EEEE_EEEE, 64'h67EE_EEEE_EEEE_EEEE,
                                   64'h45EE_EEEE_EEEE_EEEE, 64'h23EE_EEEE_EEEE_EEEE,
                                   64'h01EE_EEEE_EEEE_EEEE}},
        // R4
        '{3'd1, 3'd4, 6'd2, 4'd4, {NONE, 64'h6EEE_EEEE_EEEE_EEEE, 64'h5EEE_EEEE_EEEE_EEEE,
                                   64'h1EEE_EEEE_EEEE_EEEE, 64'h0EEE_EEEE_EEEE_EEEE}},
        // R5
        '{3'd2, 3'd3, 6'd8, 4'd5, {NONE, NONE, 64'h89FF_EEEE_EEEE_EEEE,
                                   64'h4567_EEEE_EEEE_EEEE, 64'h0123_EEEE_EEEE_EEEE}},
        // R6
        '{3'd3, 3'd2, 6'd2, 4'd6, {NONE, NONE, NONE, 64'h5EEE_EEEE_EEEE_EEEE,
                                   64'h0EEE_EEEE_EEEE_EEEE}},
        // R7
        '{3'd4, 3'd2, 6'd16, 4'd7, {NONE, NONE, NONE, 64'h89FF_FFFF_EEEE_EEEE,
                                    64'h0123_4567_EEEE_EEEE}},
        // R8
        '{3'd5, 3'd1, 6'd4, 4'd8, {NONE, NONE, NONE, NONE, 64'h05EE_EEEE_EEEE_EEEE}},
        // R9
        '{3'd6, 3'd1, 6'd32, 4'd9, {NONE, NONE, NONE, NONE, 64'h0123_4567_89FF_FFFF}}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        grp_valid = 1'b0;
    logic        grp_ready;
    logic [74:0] grp_i_data = '0;
    logic [4:0]  grp_i_ctl = '0;
    logic [74:0] grp_q_data = '0;
    logic [4:0]  grp_q_ctl = '0;
    logic [39:0] lane_octet;
    logic [4:0]  lane_sof;
    logic [4:0]  lane_en;
    logic        frame_active;

    int checks = 0;
    int fails  = 0;

    always #(CLK_HALF) clk = ~clk;

    lane_packer u_lane_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .grp_valid    (grp_valid),
        .grp_ready    (grp_ready),
        .grp_i_data   (grp_i_data),
        .grp_i_ctl    (grp_i_ctl),
        .grp_q_data   (grp_q_data),
        .grp_q_ctl    (grp_q_ctl),
        .lane_octet   (lane_octet),
        .lane_sof     (lane_sof),
        .lane_en      (lane_en),
        .frame_active (frame_active)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [14:0] tdata(int g, logic [3:0] t);
        return {4'(g), t, 7'(int'(t) * 9 + g * 5 + 1)};
    endfunction

    function automatic logic [15:0] exp_word(int g, logic [3:0] tok);
        if (tok == 4'hF) return 16'h0000;
        return {tdata(g, tok), tok[0] ^ 1'(g)};
    endfunction

    // Present group g on the inputs (does not touch grp_valid).
    task automatic put_group(input int g);
        for (int k = 0; k < 5; k++) begin
            grp_i_data[15*k +: 15] = tdata(g, 4'(k));
            grp_i_ctl[k]           = 1'(k) ^ 1'(g);
            grp_q_data[15*k +: 15] = tdata(g, 4'(5 + k));
            grp_q_ctl[k]           = 1'(5 + k) ^ 1'(g);
        end
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        grp_valid = 1'b0;
        mode_sel = m;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Expected octets and markers for character c of group g under vector v.
    task automatic expect_char(input vec_t v, input int g, input int c,
                               output logic [39:0] eo, output logic [4:0] es);
        eo = '0;
        es = '0;
        for (int l = 0; l < 5; l++) begin
            if (l < int'(v.lanes)) begin
                logic [3:0]  tok;
                logic [15:0] w;
                tok = v.lay[l][63 - 4*(c/2) -: 4];
                w   = exp_word(g, tok);
                eo[8*l +: 8] = (c % 2 == 1) ? w[7:0] : w[15:8];
                es[l] = (c == 0);
            end
        end
    endtask

    // Walk one frame starting at the current negedge (character 0 visible).
    task automatic walk_frame(input vec_t v, input int g);
        for (int c = 0; c < int'(v.flen); c++) begin
            logic [39:0] eo;
            logic [4:0]  es;
            string       rq;
            expect_char(v, g, c, eo, es);
            rq = $sformatf("R%0d", v.req);
            check(lane_octet == eo, rq, $sformatf("octets char %0d", c), 64'(lane_octet), 64'(eo));
            check(lane_sof == es, "R11", $sformatf("sof char %0d", c), 64'(lane_sof), 64'(es));
            check(grp_ready == (c == int'(v.flen) - 1), "R12", $sformatf("ready char %0d", c),
                  64'(grp_ready), 64'(c == int'(v.flen) - 1));
            @(negedge clk);
        end
    endtask

    task automatic check_idle(input string tag);
        check(frame_active == 1'b0 && lane_octet == '0 && lane_sof == '0, tag, "idle outputs",
              {23'd0, frame_active, lane_octet}, 64'd0);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // Table walk: every layout code.
        for (int i = 0; i < 7; i++) begin
            vec_t v;
            v = VECS[i];
            do_reset(v.mode);
            // R1: reset state after release
            check(grp_ready == 1'b1, "R1", "ready after reset", 64'(grp_ready), 64'd1);
            check_idle("R1");
            // R10: low lanes enabled
            check(lane_en == 5'((1 << v.lanes) - 1), "R10", "lane enables",
                  64'(lane_en), 64'((1 << v.lanes) - 1));
            put_group(i + 1);
            grp_valid = 1'b1;
            @(negedge clk);
            grp_valid = 1'b0;
            walk_frame(v, i + 1);
            // R12: no pending group, block goes idle
            check_idle("R12");
            check(grp_ready == 1'b1, "R12", "ready when idle", 64'(grp_ready), 64'd1);
        end

        // R2: explicit word format in the single-lane I/Q layout.
        do_reset(3'd5);
        grp_i_data = '0; grp_q_data = '0; grp_i_ctl = '0; grp_q_ctl = '0;
        grp_i_data[14:0] = 15'h6B3C; grp_i_ctl[0] = 1'b1;
        grp_q_data[14:0] = 15'h0001; grp_q_ctl[0] = 1'b0;
        grp_valid = 1'b1;
        @(negedge clk);
        grp_valid = 1'b0;
        check(lane_octet[7:0] == 8'hD6, "R2", "upper octet of I0", 64'(lane_octet[7:0]), 64'hD6);
        @(negedge clk);
        check(lane_octet[7:0] == 8'h79, "R2", "lower octet of I0", 64'(lane_octet[7:0]), 64'h79);
        @(negedge clk);
        check(lane_octet[7:0] == 8'h00, "R2", "upper octet of Q0", 64'(lane_octet[7:0]), 64'h00);
        @(negedge clk);
        check(lane_octet[7:0] == 8'h02, "R2", "lower octet of Q0", 64'(lane_octet[7:0]), 64'h02);

        // R12: second group held valid during a frame is not taken until the last character.
        do_reset(3'd2);
        put_group(11);
        grp_valid = 1'b1;
        @(negedge clk);
        put_group(12);
        walk_frame(VECS[2], 11);
        grp_valid = 1'b0;
        check(lane_sof == 5'b00111 && frame_active, "R12", "next frame starts without gap",
              64'(lane_sof), 64'h07);
        walk_frame(VECS[2], 12);
        check_idle("R12");

        // R12: back-to-back frames in the shortest layout.
        do_reset(3'd3);
        put_group(13);
        grp_valid = 1'b1;
        @(negedge clk);
        put_group(14);
        walk_frame(VECS[3], 13);
        grp_valid = 1'b0;
        walk_frame(VECS[3], 14);
        check_idle("R12");

        // R13: mode change outside reset is ignored.
        do_reset(3'd3);
        mode_sel = 3'd0;
        put_group(15);
        grp_valid = 1'b1;
        @(negedge clk);
        grp_valid = 1'b0;
        check(lane_en == 5'b00011, "R13", "enables keep captured layout", 64'(lane_en), 64'h03);
        walk_frame(VECS[3], 15);

        // R14: code 7 disables everything and ignores offered groups.
        do_reset(3'd7);
        check(lane_en == 5'b00000, "R14", "no lanes enabled", 64'(lane_en), 64'd0);
        put_group(16);
        grp_valid = 1'b1;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            check(grp_ready == 1'b0, "R14", "ready held low", 64'(grp_ready), 64'd0);
            check_idle("R14");
        end
        grp_valid = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule